// File: doc/BRIEF.md
# SPI EEPROM Command Controller

This block is the command side of a serial EEPROM with an 8K-byte array. It acts as an SPI slave in clock modes 0 and 3 and decodes an 8-bit opcode at the start of every chip-select window. It serves streaming array reads and buffers up to one 32-byte page of write data. It also keeps a status byte that holds the write-enable latch, the busy indication, a software flag, the block-lock code, the watchdog period code and the write-protect-enable bit. The array itself sits outside the block, behind a byte-wide port with a combinational read.

The SPI pins are sampled by the block's own clock through two-flop synchronisers, so SCK phases must each last at least four clock cycles. A write is accepted only when chip select rises on a byte boundary after at least one data byte. When a write is accepted, a commit timer runs for WRITE_TICKS cycles. During the first PAGE_BYTES cycles of that run, the buffered bytes are copied into the array. A status write takes effect when the timer ends. Two things can stop an array write. Block-lock protection covers part or all of the array. The write-protect pin, combined with the enable bit, locks the status byte.

Top module: `eep_spi_ctrl`

## Requirements
- R1: `spi_so_oe` is 1 only while chip select is low. Opcode 0x05 returns the status byte on SO, MSB first, in both SPI modes, and repeats it for every further byte. The status bits are 7 lock-enable (LE), 6 flag, 5:4 watchdog code, 3:2 block code, 1 write-enable latch (WEL), 0 busy. The byte is 0x00 after reset.
- R2: Opcode 0x06 sets WEL only when CS rises after exactly 8 bits. Opcode 0x04 clears WEL and the flag under the same framing rule.
- R3: Opcode 0x00, framed as 8 bits, sets the flag.
- R4: Opcode 0x03 followed by a 16-bit address streams bytes from that address. The address increments after each byte, and 0x1FFF is followed by 0x0000.
- R5: Opcode 0x02 followed by a 16-bit address stores data bytes at increasing offsets that wrap inside the 32-byte page. A later byte overwrites an earlier byte at the same offset.
- R6: A write or status write starts only if CS rises right after bit 0 of a data byte. Otherwise nothing is written, and WEL keeps its value.
- R7: A write or status write sent while WEL is 0 has no effect.
- R8: Block code 01 protects 0x1800–0x1FFF, 10 protects 0x1000–0x1FFF, and 11 protects everything. A write to a protected page is rejected, and WEL stays set.
- R9: An accepted write sets busy for WRITE_TICKS cycles. The status byte stays readable during that time. When busy ends, WEL is cleared.
- R10: Opcode 0x01 with one data byte loads bits 7, 5, 4, 3 and 2 when busy ends. Data bits 6, 1 and 0 are ignored. The command is refused while the WP pin is low and LE is 1.
- R11: A status write that has already started completes even if the WP pin falls during busy.
- R12: While busy is 1, new write, status-write and read commands are ignored.
- R13: SO changes only after a falling SCK edge, or when it is cleared at the start of a CS window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data in |
| spi_wp_n | input | 1 | Active-low status write-protect pin |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for SO |
| mem_addr | output | 13 | Array address |
| mem_wdata | output | 8 | Array write data |
| mem_we | output | 1 | Array write strobe |
| mem_rdata | input | 8 | Array read data (combinational on mem_addr) |

## Verification
An SCK edge reaches the logic three clock edges after the pin changes. SO therefore settles three cycles after a falling SCK edge. The bench holds every SCK phase for six cycles and samples SO just before it raises SCK, so each sampled value is already settled. Busy is sampled through a status read issued right after CS rises, which falls well inside the commit window. Results of a commit are read back only after the bench has waited WRITE_TICKS plus a margin of cycles.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [7:0] OP_FLAG_SET = 8'h00;
  localparam logic [7:0] OP_SR_WRITE = 8'h01;
  localparam logic [7:0] OP_WRITE    = 8'h02;
  localparam logic [7:0] OP_READ     = 8'h03;
  localparam logic [7:0] OP_DISABLE  = 8'h04;
  localparam logic [7:0] OP_SR_READ  = 8'h05;
  localparam logic [7:0] OP_ENABLE   = 8'h06;

  typedef enum logic [2:0] {
    PH_OPC, PH_AHI, PH_ALO, PH_DATA, PH_SRDAT, PH_STAT, PH_SKIP, PH_IGN
  } phase_t;
endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync #(
  parameter int N = 1,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] lvl
);
  logic [N-1:0] ff1_q, ff2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff1_q <= RST_VAL;
      ff2_q <= RST_VAL;
    end else begin
      ff1_q <= pin;
      ff2_q <= ff1_q;
    end
  end

  assign lvl = ff2_q;
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [7:0]               wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [7:0]               rd_data,
  output logic                     rd_vld
);
  logic [7:0]       slot_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld_q <= '0;
    else if (clr)   vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  assign rd_data = slot_q[rd_idx];
  assign rd_vld  = vld_q[rd_idx];
endmodule

// File: rtl/eep_commit_timer.sv
module eep_commit_timer #(
  parameter int TICKS = 250000,
  parameter int PAGE  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  output logic                    busy,
  output logic                    done,
  output logic [$clog2(PAGE)-1:0] idx,
  output logic                    in_page
);
  localparam int CW = $clog2(TICKS) + 1;
  localparam int PW = $clog2(PAGE);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);
  localparam logic [CW-1:0] PB   = CW'(PAGE);

  logic [CW-1:0] cnt_q;

  assign done    = busy && (cnt_q == LAST);
  assign idx     = cnt_q[PW-1:0];
  assign in_page = cnt_q < PB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end

  // a running commit is never restarted
  assert_no_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  assert_cnt_steps_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/eep_spi_ctrl.sv
module eep_spi_ctrl
  import eep_pkg::*;
#(
  parameter int MEM_BYTES   = 8192,
  parameter int PAGE_BYTES  = 32,
  parameter int WRITE_TICKS = 250000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          spi_sck,
  input  logic                          spi_cs_n,
  input  logic                          spi_si,
  input  logic                          spi_wp_n,
  output logic                          spi_so,
  output logic                          spi_so_oe,
  output logic [$clog2(MEM_BYTES)-1:0]  mem_addr,
  output logic [7:0]                    mem_wdata,
  output logic                          mem_we,
  input  logic [7:0]                    mem_rdata
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int GW = AW - PW;

  // protection decision for a page number; the top two page bits select quarters
  function automatic logic page_locked(input logic [1:0] code, input logic [GW-1:0] pg);
    case (code)
      2'b00:   page_locked = 1'b0;
      2'b01:   page_locked = (pg[GW-1:GW-2] == 2'b11);
      2'b10:   page_locked = pg[GW-1];
      default: page_locked = 1'b1;
    endcase
  endfunction

  // ---------------- pin sampling and edge events ----------------
  logic [3:0] pin_lvl;
  logic       sck_d, cs_d;
  eep_pin_sync #(.N(4), .RST_VAL(4'b1010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pin({spi_wp_n, spi_si, spi_cs_n, spi_sck}),
    .lvl(pin_lvl)
  );
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= pin_lvl[0];
      cs_d  <= pin_lvl[1];
    end
  end

  logic cs_act, sck_rise_ev, sck_fall_ev, cs_fall_ev, cs_rise_ev, si_lvl, wp_lvl;
  assign cs_act      = !pin_lvl[1];
  assign sck_rise_ev = cs_act && pin_lvl[0] && !sck_d;
  assign sck_fall_ev = cs_act && !pin_lvl[0] && sck_d;
  assign cs_fall_ev  = !pin_lvl[1] && cs_d;
  assign cs_rise_ev  = pin_lvl[1] && !cs_d;
  assign si_lvl      = pin_lvl[2];
  assign wp_lvl      = pin_lvl[3];

  // ---------------- state ----------------
  phase_t        phase;
  logic [2:0]    bit_cnt;
  logic [1:0]    byte_cnt;
  logic [7:0]    rx_sr, opc, sr_rx, sr_pend, tx_sr;
  logic [AW-9:0] addr_hi;
  logic [AW-1:0] ptr;
  logic [PW-1:0] woff;
  logic [GW-1:0] wpage, cpage;
  logic          got_data, tx_act, ld_req, so_q;
  logic          lock_en, flag, wel, kind_sr;
  logic [1:0]    wd_code, blk_code;

  logic          busy, commit_done, in_page;
  logic [PW-1:0] cidx;
  logic [7:0]    buf_rdata;
  logic          buf_rvld;

  logic [7:0] status, rx_byte;
  logic       byte_done, at_bound;
  assign status    = {lock_en, flag, wd_code, blk_code, wel, busy};
  assign rx_byte   = {rx_sr[6:0], si_lvl};
  assign byte_done = (bit_cnt == 3'd7);
  assign at_bound  = (bit_cnt == 3'd0);

  // ---------------- named events ----------------
  logic simple_ok, wren_ev, wrdi_ev, sflb_ev, wrsr_ok, page_ok, commit_start;
  logic buf_we, buf_clr, stat_load, read_load;
  assign simple_ok = cs_rise_ev && (phase == PH_SKIP) && (byte_cnt == 2'd1) && at_bound;
  assign wren_ev   = simple_ok && (opc == OP_ENABLE);
  assign wrdi_ev   = simple_ok && (opc == OP_DISABLE);
  assign sflb_ev   = simple_ok && (opc == OP_FLAG_SET);
  assign wrsr_ok   = cs_rise_ev && (phase == PH_SKIP) && (opc == OP_SR_WRITE) &&
                     (byte_cnt == 2'd2) && at_bound && wel && !busy &&
                     !(lock_en && !wp_lvl);
  assign page_ok   = cs_rise_ev && (phase == PH_DATA) && (opc == OP_WRITE) &&
                     at_bound && got_data && wel && !busy &&
                     !page_locked(blk_code, wpage);
  assign commit_start = wrsr_ok || page_ok;
  assign buf_we    = sck_rise_ev && byte_done && (phase == PH_DATA) && (opc == OP_WRITE);
  assign buf_clr   = (cs_fall_ev && !busy) || commit_done;
  assign stat_load = sck_rise_ev && byte_done &&
                     (((phase == PH_OPC) && (rx_byte == OP_SR_READ)) || (phase == PH_STAT));
  assign read_load = sck_rise_ev && byte_done && (opc == OP_READ) &&
                     ((phase == PH_ALO) || (phase == PH_DATA));

  // ---------------- protocol sequencing ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_OPC; bit_cnt <= '0; byte_cnt <= '0; rx_sr <= '0; opc <= '0;
      addr_hi <= '0; ptr <= '0; woff <= '0; wpage <= '0; got_data <= 1'b0; sr_rx <= '0;
    end else begin
      if (cs_fall_ev) begin
        phase <= PH_OPC; bit_cnt <= '0; byte_cnt <= '0; got_data <= 1'b0;
      end else if (sck_rise_ev) begin
        rx_sr   <= rx_byte;
        bit_cnt <= bit_cnt + 1'b1;
        if (byte_done) begin
          if (byte_cnt != 2'd3) byte_cnt <= byte_cnt + 1'b1;
          case (phase)
            PH_OPC: begin
              opc <= rx_byte;
              case (rx_byte)
                OP_SR_READ:        phase <= PH_STAT;
                OP_READ, OP_WRITE: phase <= busy ? PH_IGN : PH_AHI;
                OP_SR_WRITE:       phase <= busy ? PH_IGN : PH_SRDAT;
                default:           phase <= PH_SKIP;
              endcase
            end
            PH_AHI: begin
              addr_hi <= rx_byte[AW-9:0];
              phase   <= PH_ALO;
            end
            PH_ALO: begin
              ptr   <= {addr_hi, rx_byte};
              woff  <= rx_byte[PW-1:0];
              wpage <= {addr_hi, rx_byte[7:PW]};
              phase <= PH_DATA;
            end
            PH_DATA: begin
              if (opc == OP_WRITE) begin
                woff     <= woff + 1'b1;
                got_data <= 1'b1;
              end
            end
            PH_SRDAT: begin
              sr_rx <= rx_byte;
              phase <= PH_SKIP;
            end
            default: ;
          endcase
        end
      end
      if (ld_req) ptr <= ptr + 1'b1;
    end
  end

  // ---------------- serial output path ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0; tx_act <= 1'b0; ld_req <= 1'b0; so_q <= 1'b0;
    end else if (cs_fall_ev) begin
      tx_act <= 1'b0; ld_req <= 1'b0; so_q <= 1'b0;
    end else begin
      if (ld_req) begin
        tx_sr  <= mem_rdata;
        tx_act <= 1'b1;
        ld_req <= 1'b0;
      end else if (stat_load) begin
        tx_sr  <= status;
        tx_act <= 1'b1;
      end else if (sck_fall_ev && tx_act) begin
        so_q  <= tx_sr[7];
        tx_sr <= {tx_sr[6:0], 1'b0};
      end
      if (read_load) ld_req <= 1'b1;
    end
  end

  assign spi_so    = so_q;
  assign spi_so_oe = cs_act;

  // ---------------- status register ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_en <= 1'b0; flag <= 1'b0; wd_code <= '0; blk_code <= '0; wel <= 1'b0;
      kind_sr <= 1'b0; cpage <= '0; sr_pend <= '0;
    end else begin
      if (wren_ev) wel <= 1'b1;
      if (wrdi_ev) begin
        wel  <= 1'b0;
        flag <= 1'b0;
      end
      if (sflb_ev) flag <= 1'b1;
      if (wrsr_ok) begin
        kind_sr <= 1'b1;
        sr_pend <= sr_rx;
      end
      if (page_ok) begin
        kind_sr <= 1'b0;
        cpage   <= wpage;
      end
      if (commit_done) begin
        wel <= 1'b0;
        if (kind_sr) begin
          lock_en  <= sr_pend[7];
          wd_code  <= sr_pend[5:4];
          blk_code <= sr_pend[3:2];
        end
      end
    end
  end

  // ---------------- page buffer and commit ----------------
  eep_page_buf #(.DEPTH(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr),
    .wr_en(buf_we), .wr_idx(woff), .wr_data(rx_byte),
    .rd_idx(cidx), .rd_data(buf_rdata), .rd_vld(buf_rvld)
  );

  eep_commit_timer #(.TICKS(WRITE_TICKS), .PAGE(PAGE_BYTES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(commit_start),
    .busy(busy), .done(commit_done), .idx(cidx), .in_page(in_page)
  );

  assign mem_we    = busy && in_page && !kind_sr && buf_rvld;
  assign mem_wdata = buf_rdata;
  assign mem_addr  = busy ? {cpage, cidx} : ptr;

  // ---------------- assertions ----------------
  assert_so_on_fall_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall_ev && !cs_fall_ev) |=> $stable(spi_so));
  assert_wel_on_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(cs_rise_ev));
  assert_commit_on_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cs_rise_ev) && $past(wel)));
  assert_no_locked_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !page_locked(blk_code, mem_addr[AW-1:PW]));
  assert_wel_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  assert_sr_unlocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && kind_sr) |-> $past(wp_lvl || !lock_en));
endmodule

// File: tb/eep_spi_ctrl_test.sv
module eep_spi_ctrl_test;
  localparam int WT = 600;
  localparam int HP = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1;
  logic so, so_oe, mem_we;
  logic [12:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [7:0]  mem [8192];
  logic [7:0]  txb [64];
  logic [7:0]  rxb [64];
  logic [7:0]  wdat [40];
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  eep_spi_ctrl #(.WRITE_TICKS(WT)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .spi_wp_n(wp_n), .spi_so(so), .spi_so_oe(so_oe), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  function automatic logic [7:0] initv(input int a);
    int t;
    t = a * 7 + 3 + (a >> 8);
    return t[7:0];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input int nbytes, input int extra, input bit m3);
    int nbits;
    nbits = nbytes * 8 + extra;
    for (int i = 0; i < 64; i++) rxb[i] = 8'h00;
    sck = m3;
    repeat (HP) @(negedge clk);
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      if (m3) sck = 1'b0;
      si = txb[k / 8][7 - (k % 8)];
      repeat (HP) @(negedge clk);
      rxb[k / 8][7 - (k % 8)] = so;
      sck = 1'b1;
      repeat (HP) @(negedge clk);
      if (!m3) sck = 1'b0;
    end
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (3 * HP) @(negedge clk);
  endtask

  task automatic op1(input logic [7:0] op, input int extra);
    for (int i = 0; i < 64; i++) txb[i] = 8'h00;
    txb[0] = op;
    xfer(1, extra, 1'b0);
  endtask

  task automatic rdsr(output logic [7:0] s, input bit m3);
    for (int i = 0; i < 64; i++) txb[i] = 8'h00;
    txb[0] = 8'h05;
    xfer(3, 0, m3);
    s = rxb[1];
    if (rxb[2] != rxb[1]) chk("R1 status repeat", rxb[2], rxb[1]);
  endtask

  task automatic wrsr(input logic [7:0] v);
    for (int i = 0; i < 64; i++) txb[i] = 8'h00;
    txb[0] = 8'h01; txb[1] = v;
    xfer(2, 0, 1'b0);
  endtask

  task automatic do_write(input int addr, input int n, input int extra);
    for (int i = 0; i < 64; i++) txb[i] = 8'h00;
    txb[0] = 8'h02; txb[1] = 8'(addr >> 8); txb[2] = 8'(addr);
    for (int i = 0; i < n; i++) txb[3 + i] = wdat[i];
    xfer(3 + n, extra, 1'b0);
  endtask

  task automatic do_read(input int addr, input int n);
    for (int i = 0; i < 64; i++) txb[i] = 8'h00;
    txb[0] = 8'h03; txb[1] = 8'(addr >> 8); txb[2] = 8'(addr);
    xfer(3 + n, 0, 1'b0);
  endtask

  task automatic wait_commit();
    repeat (WT + 50) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk("R1 so_oe idle", so_oe, 0);
    cs_n = 1'b0; repeat (HP) @(negedge clk);
    chk("R1 so_oe selected", so_oe, 1);
    cs_n = 1'b1; repeat (HP) @(negedge clk);
    chk("R1 so_oe released", so_oe, 0);
    rdsr(s, 1'b0);
    chk("R1 status after reset", s, 8'h00);
  endtask

  task automatic t_enable();
    logic [7:0] s;
    op1(8'h06, 1);
    rdsr(s, 1'b0); chk("R2 WREN with 9 bits ignored", s, 8'h00);
    op1(8'h06, 0);
    rdsr(s, 1'b0); chk("R2 WREN sets WEL", s, 8'h02);
    op1(8'h04, 0);
    rdsr(s, 1'b0); chk("R2 0x04 clears WEL", s, 8'h00);
  endtask

  task automatic t_flag();
    logic [7:0] s;
    op1(8'h00, 0);
    rdsr(s, 1'b0); chk("R3 flag set", s, 8'h40);
    rdsr(s, 1'b1); chk("R1 mode 3 status read", s, 8'h40);
    op1(8'h06, 0);
    op1(8'h04, 0);
    rdsr(s, 1'b0); chk("R2 0x04 clears flag and WEL", s, 8'h00);
  endtask

  task automatic t_read_wrap();
    do_read(16'h1FFE, 4);
    chk("R4 read 1FFE", rxb[3], initv(16'h1FFE));
    chk("R4 read 1FFF", rxb[4], initv(16'h1FFF));
    chk("R4 wrap to 0000", rxb[5], initv(0));
    chk("R4 read 0001", rxb[6], initv(1));
  endtask

  task automatic t_page();
    logic [7:0] s;
    op1(8'h06, 0);
    wdat[0] = 8'h31; wdat[1] = 8'h32; wdat[2] = 8'h33;
    do_write(16'h0105, 3, 0);
    rdsr(s, 1'b0); chk("R9 busy and WEL during commit", s, 8'h03);
    wait_commit();
    rdsr(s, 1'b0); chk("R9 idle and WEL cleared", s, 8'h00);
    do_read(16'h0105, 3);
    chk("R5 byte 0", rxb[3], 8'h31);
    chk("R5 byte 1", rxb[4], 8'h32);
    chk("R5 byte 2", rxb[5], 8'h33);
    op1(8'h06, 0);
    wdat[0] = 8'hA0; wdat[1] = 8'hA1; wdat[2] = 8'hA2; wdat[3] = 8'hA3;
    do_write(16'h021E, 4, 0);
    wait_commit();
    do_read(16'h021E, 2);
    chk("R5 page end 1E", rxb[3], 8'hA0);
    chk("R5 page end 1F", rxb[4], 8'hA1);
    do_read(16'h0200, 3);
    chk("R5 wrapped to page start", rxb[3], 8'hA2);
    chk("R5 wrapped offset 1", rxb[4], 8'hA3);
    chk("R5 no write past wrap", rxb[5], initv(16'h0202));
    do_read(16'h0220, 1);
    chk("R5 next page untouched", rxb[3], initv(16'h0220));
    op1(8'h06, 0);
    for (int i = 0; i < 33; i++) wdat[i] = 8'(8'h50 + i);
    do_write(16'h0300, 33, 0);
    wait_commit();
    do_read(16'h0300, 2);
    chk("R5 33rd byte overwrites first", rxb[3], 8'h70);
    chk("R5 second byte kept", rxb[4], 8'h51);
  endtask

  task automatic t_framing();
    logic [7:0] s;
    op1(8'h06, 0);
    wdat[0] = 8'h77;
    do_write(16'h0400, 1, 3);
    rdsr(s, 1'b0); chk("R6 off-boundary write dropped, WEL kept", s, 8'h02);
    do_read(16'h0400, 1);
    chk("R6 memory unchanged", rxb[3], initv(16'h0400));
    do_write(16'h0400, 0, 0);
    rdsr(s, 1'b0); chk("R6 no data byte, no commit", s, 8'h02);
    op1(8'h04, 0);
    do_write(16'h0500, 1, 0);
    rdsr(s, 1'b0); chk("R7 no WEL, no commit", s, 8'h00);
    do_read(16'h0500, 1);
    chk("R7 memory unchanged", rxb[3], initv(16'h0500));
    wrsr(8'h0C);
    rdsr(s, 1'b0); chk("R7 status write without WEL ignored", s, 8'h00);
  endtask

  task automatic blk_case(input logic [7:0] code, input int bad, input int good, input string tag);
    logic [7:0] s;
    op1(8'h06, 0); wrsr(code); wait_commit();
    rdsr(s, 1'b0); chk({tag, " code loaded"}, s, code);
    op1(8'h06, 0);
    wdat[0] = 8'h5A;
    do_write(bad, 1, 0);
    rdsr(s, 1'b0); chk({tag, " locked write rejected"}, s, code | 8'h02);
    do_read(bad, 1);
    chk({tag, " locked byte unchanged"}, rxb[3], initv(bad));
    if (good >= 0) begin
      wdat[0] = 8'h5B;
      do_write(good, 1, 0);
      wait_commit();
      do_read(good, 1);
      chk({tag, " open byte written"}, rxb[3], 8'h5B);
    end else begin
      op1(8'h04, 0);
    end
  endtask

  task automatic t_block();
    logic [7:0] s;
    blk_case(8'h04, 16'h1800, 16'h17E0, "R8 quarter");
    blk_case(8'h08, 16'h1000, 16'h0FE0, "R8 half");
    blk_case(8'h0C, 16'h0010, -1, "R8 all");
    op1(8'h06, 0); wrsr(8'h00); wait_commit();
    rdsr(s, 1'b0); chk("R8 protection cleared", s, 8'h00);
  endtask

  task automatic t_status_write();
    logic [7:0] s;
    op1(8'h06, 0); wrsr(8'hF3); wait_commit();
    rdsr(s, 1'b0); chk("R10 writable bits only", s, 8'hB0);
    wp_n = 1'b0;
    op1(8'h06, 0); wrsr(8'h00);
    rdsr(s, 1'b0); chk("R10 locked status write refused", s, 8'hB2);
    wp_n = 1'b1;
    wrsr(8'h00); wait_commit();
    rdsr(s, 1'b0); chk("R10 unlocked status write", s, 8'h00);
    op1(8'h06, 0); wrsr(8'h80);
    wp_n = 1'b0;
    rdsr(s, 1'b0); chk("R11 old bits visible while busy", s, 8'h03);
    wait_commit();
    rdsr(s, 1'b0); chk("R11 started write completes", s, 8'h80);
    wp_n = 1'b1;
    op1(8'h06, 0); wrsr(8'h00); wait_commit();
    rdsr(s, 1'b0); chk("R10 cleared after raising WP", s, 8'h00);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] s;
    op1(8'h06, 0);
    wdat[0] = 8'h11;
    do_write(16'h0600, 1, 0);
    wdat[0] = 8'h22;
    do_write(16'h0700, 1, 0);
    wait_commit();
    rdsr(s, 1'b0); chk("R12 second write did not restart", s, 8'h00);
    do_read(16'h0700, 1);
    chk("R12 write while busy ignored", rxb[3], initv(16'h0700));
    do_read(16'h0600, 1);
    chk("R12 first write kept", rxb[3], 8'h11);
  endtask

  initial begin
    for (int a = 0; a < 8192; a++) mem[a] = initv(a);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_enable();
    t_flag();
    t_read_wrap();
    t_page();
    t_framing();
    t_block();
    t_status_write();
    t_busy_ignore();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule